// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Loader

This block receives configuration words over a three-line serial port (serial clock, serial data and a load strobe) and files each word into one of four parallel configuration registers. All logic runs on the system clock: the three serial lines pass through synchronizers, and the block detects their rising edges. Each rising edge of the serial clock shifts one data bit into a 24-bit shift register, most significant bit first.

A rising edge of the load strobe ends the frame. The two bits that arrived last form a destination code. The remaining 22 bits are the payload, and the destination code decides which register takes it. If the number of serial clocks since the previous load strobe was not exactly 24, the block drops the word and raises an error pulse instead. Each register comes with a one-cycle update pulse, so the logic that follows can act on new settings.

The block does not interpret the payload. The four registers hold the settings for the reference divider, the A/B divider pair, the general function controls and the initialization controls. They are passed out as raw bits.

Top module: `cfg3w_loader`

## Requirements
- R1: After a synchronous reset all four registers read zero, and no update or error pulse is raised.
- R2: Bits are taken on rising edges of `cfg_sclk`, first bit into the MSB. After a valid frame the selected register holds the 22 bits that arrived first, first-arrived bit in register bit 21.
- R3: Destination code 00 (the last two bits, the earlier-arriving one being the code's MSB) writes only `ref_word` and pulses only `ref_stb`.
- R4: Destination code 01 writes only `ab_word` and pulses only `ab_stb`.
- R5: Destination code 10 writes only `fn_word` and pulses only `fn_stb`.
- R6: Destination code 11 writes the payload into both `ini_word` and `fn_word`, and pulses `ini_stb` and `fn_stb` in the same cycle.
- R7: A load strobe that follows fewer or more than 24 serial clocks leaves every register unchanged, raises no update pulse and raises `frame_err` for exactly one cycle.
- R8: Shifting bits without a load strobe changes no register and raises no pulse. The transfer happens only on the rising edge of `cfg_latch`.
- R9: Every update pulse lasts exactly one system clock cycle per accepted frame.
- R10: Each load strobe restarts the bit count, so back-to-back frames are judged independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sclk | input | 1 | Serial clock, asynchronous |
| cfg_sdata | input | 1 | Serial data, asynchronous |
| cfg_latch | input | 1 | Load strobe, asynchronous |
| ref_word | output | 22 | Reference divider settings |
| ab_word | output | 22 | A/B divider settings |
| fn_word | output | 22 | Function settings |
| ini_word | output | 22 | Initialization settings |
| ref_stb | output | 1 | One-cycle update pulse for `ref_word` |
| ab_stb | output | 1 | One-cycle update pulse for `ab_word` |
| fn_stb | output | 1 | One-cycle update pulse for `fn_word` |
| ini_stb | output | 1 | One-cycle update pulse for `ini_word` |
| frame_err | output | 1 | One-cycle pulse when a frame of the wrong length is dropped |

## Verification
Frames go to each of the four destination codes with distinct payloads. All-zero and almost-all-ones payloads land on registers that already hold other values, which exposes stuck bits and swapped bit order. The initialization code is followed by a plain function write, which shows that the mirror copy and the direct write do not disturb each other. Frames of 0, 20 and 25 bits, and a full frame held back from its load strobe, separate the length check from the transfer trigger.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    localparam int WORD_W      = 24;
    localparam int SEL_W       = 2;
    localparam int DATA_W      = WORD_W - SEL_W;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_LATCH   = 4;

    localparam int LAT_REF = 0;
    localparam int LAT_AB  = 1;
    localparam int LAT_FN  = 2;
    localparam int LAT_INI = 3;

    localparam int LINE_SCLK = 0;
    localparam int LINE_DATA = 1;
    localparam int LINE_LE   = 2;
    localparam int NUM_LINES = 3;

    typedef enum logic [SEL_W-1:0] {
        DST_REF = 2'b00,
        DST_AB  = 2'b01,
        DST_FN  = 2'b10,
        DST_INI = 2'b11
    } dest_e;

    typedef struct packed {
        logic [DATA_W-1:0] payload;
        dest_e             dest;
    } frame_t;

    // Set of registers written by one destination code
    function automatic logic [NUM_LATCH-1:0] dest_mask(input dest_e d);
        logic [NUM_LATCH-1:0] m;
        m = '0;
        case (d)
            DST_REF: m[LAT_REF] = 1'b1;
            DST_AB:  m[LAT_AB]  = 1'b1;
            DST_FN:  m[LAT_FN]  = 1'b1;
            DST_INI: begin
                m[LAT_INI] = 1'b1;
                m[LAT_FN]  = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level_q,
    output logic [WIDTH-1:0] rise_q
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              last;

            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                    last  <= 1'b0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[g]};
                    last  <= chain[STAGES-1];
                end
            end

            assign level_q[g] = chain[STAGES-1];
            assign rise_q[g]  = chain[STAGES-1] & ~last;
        end
    endgenerate

endmodule

// File: rtl/cfg3w_collect.sv
module cfg3w_collect
    import cfg3w_pkg::*;
#(
    parameter int WORD_BITS = WORD_W,
    localparam int CW = $clog2(WORD_BITS + 2) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sclk_rise,
    input  logic                 le_rise,
    input  logic                 dat,
    output logic [WORD_BITS-1:0] word_q,
    output logic                 word_vld,
    output logic                 frame_err
);

    localparam logic [CW-1:0] FULL = CW'(WORD_BITS);
    localparam logic [CW-1:0] CAP  = CW'(WORD_BITS + 1);

    logic [WORD_BITS-1:0] shreg;
    logic [CW-1:0]        cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            cnt       <= '0;
            word_q    <= '0;
            word_vld  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            word_vld  <= 1'b0;
            frame_err <= 1'b0;
            if (le_rise) begin
                if (cnt == FULL) begin
                    word_vld <= 1'b1;
                    word_q   <= shreg;
                end else begin
                    frame_err <= 1'b1;
                end
                cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[WORD_BITS-2:0], dat};
                if (cnt != CAP) cnt <= cnt + 1'b1;
            end
        end
    end

    p_full_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (le_rise && cnt == FULL) |=> (word_vld && !frame_err));

    p_bad_length_r7: assert property (@(posedge clk) disable iff (rst)
        (le_rise && cnt != FULL) |=> (frame_err && !word_vld));

    p_count_restart_r10: assert property (@(posedge clk) disable iff (rst)
        le_rise |=> (cnt == '0));

    p_count_bounded_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CAP);

endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank
    import cfg3w_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NL = NUM_LATCH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  word_vld,
    input  logic [DW+SEL_W-1:0]   word,
    output logic [NL-1:0][DW-1:0] lat_q,
    output logic [NL-1:0]         upd_q
);

    frame_t          frm;
    logic [NL-1:0]   hit;

    assign frm = frame_t'(word);
    assign hit = word_vld ? NL'(dest_mask(frm.dest)) : '0;

    genvar k;
    generate
        for (k = 0; k < NL; k++) begin : g_lat
            logic [DW-1:0] r_val;
            logic          r_upd;

            always_ff @(posedge clk) begin
                if (rst) begin
                    r_val <= '0;
                    r_upd <= 1'b0;
                end else begin
                    r_upd <= hit[k];
                    if (hit[k]) r_val <= frm.payload;
                end
            end

            assign lat_q[k] = r_val;
            assign upd_q[k] = r_upd;
        end
    endgenerate

    p_strobe_once_r9: assert property (@(posedge clk) disable iff (rst)
        upd_q[LAT_REF] |=> !upd_q[LAT_REF]);

    p_init_mirrors_r6: assert property (@(posedge clk) disable iff (rst)
        upd_q[LAT_INI] |-> (upd_q[LAT_FN] && lat_q[LAT_FN] == lat_q[LAT_INI]));

    p_quiet_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !word_vld |=> $stable(lat_q));

    p_one_target_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({upd_q[LAT_FN], upd_q[LAT_AB], upd_q[LAT_REF]}));

endmodule

// File: rtl/cfg3w_loader.sv
module cfg3w_loader
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sclk,
    input  logic              cfg_sdata,
    input  logic              cfg_latch,
    output logic [DATA_W-1:0] ref_word,
    output logic [DATA_W-1:0] ab_word,
    output logic [DATA_W-1:0] fn_word,
    output logic [DATA_W-1:0] ini_word,
    output logic              ref_stb,
    output logic              ab_stb,
    output logic              fn_stb,
    output logic              ini_stb,
    output logic              frame_err
);

    logic [NUM_LINES-1:0]             lvl;
    logic [NUM_LINES-1:0]             rise;
    logic [NUM_LINES-1:0]             raw;
    logic [WORD_W-1:0]                word;
    logic                             word_vld;
    logic [NUM_LATCH-1:0][DATA_W-1:0] lat;
    logic [NUM_LATCH-1:0]             upd;

    always_comb begin
        raw            = '0;
        raw[LINE_SCLK] = cfg_sclk;
        raw[LINE_DATA] = cfg_sdata;
        raw[LINE_LE]   = cfg_latch;
    end

    cfg3w_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw),
        .level_q  (lvl),
        .rise_q   (rise)
    );

    cfg3w_collect #(.WORD_BITS(WORD_W)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (rise[LINE_SCLK]),
        .le_rise   (rise[LINE_LE]),
        .dat       (lvl[LINE_DATA]),
        .word_q    (word),
        .word_vld  (word_vld),
        .frame_err (frame_err)
    );

    cfg3w_bank #(.DW(DATA_W), .NL(NUM_LATCH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .word     (word),
        .lat_q    (lat),
        .upd_q    (upd)
    );

    assign ref_word = lat[LAT_REF];
    assign ab_word  = lat[LAT_AB];
    assign fn_word  = lat[LAT_FN];
    assign ini_word = lat[LAT_INI];
    assign ref_stb  = upd[LAT_REF];
    assign ab_stb   = upd[LAT_AB];
    assign fn_stb   = upd[LAT_FN];
    assign ini_stb  = upd[LAT_INI];

endmodule

// File: tb/sim_cfg3w_loader.sv
`timescale 1ns/1ps
module sim_cfg3w_loader;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic le = 1'b0;
    logic [21:0] ref_w, ab_w, fn_w, ini_w;
    logic ref_s, ab_s, fn_s, ini_s, ferr;

    always #2.5 clk = ~clk;

    cfg3w_loader u0 (
        .clk(clk), .rst(rst), .cfg_sclk(sclk), .cfg_sdata(sdat), .cfg_latch(le),
        .ref_word(ref_w), .ab_word(ab_w), .fn_word(fn_w), .ini_word(ini_w),
        .ref_stb(ref_s), .ab_stb(ab_s), .fn_stb(fn_s), .ini_stb(ini_s),
        .frame_err(ferr)
    );

    int checks = 0;
    int fails  = 0;

    // pulse counters, index 0..3 = ref, ab, fn, ini ; 4 = error
    int n_pulse [5];
    int n_double = 0;
    logic [4:0] prev_p = '0;

    always @(posedge clk) begin
        logic [4:0] p;
        p = {ferr, ini_s, fn_s, ab_s, ref_s};
        for (int i = 0; i < 5; i++) begin
            if (p[i]) n_pulse[i] = n_pulse[i] + 1;
        end
        if (|(p & prev_p & 5'b01111)) n_double = n_double + 1;
        prev_p = p;
    end

    // stimulus table: {word, number of serial clocks}
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {24'hA5C3F0, 6'd24},
        {24'h123455, 6'd24},
        {24'hFEDCBA, 6'd24},
        {24'h0F0F0F, 6'd24},
        {24'hFFFFFE, 6'd24},
        {24'h777774, 6'd20},
        {24'h5A5A59, 6'd25},
        {24'h000001, 6'd24},
        {24'h111111, 6'd0},
        {24'hC0FFEE, 6'd24}
    };

    logic [21:0] m_lat [4];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [23:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sdat = (i < 24) ? w[23-i] : 1'b0;
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_le();
        repeat (3) @(negedge clk);
        le = 1'b1;
        repeat (3) @(negedge clk);
        le = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_latches(input string req);
        chk(req, 32'(ref_w), 32'(m_lat[0]));
        chk(req, 32'(ab_w),  32'(m_lat[1]));
        chk(req, 32'(fn_w),  32'(m_lat[2]));
        chk(req, 32'(ini_w), 32'(m_lat[3]));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) n_pulse[i] = 0;
        for (int i = 0; i < 4; i++) m_lat[i] = '0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state
        check_latches("R1 reset value");
        chk("R1 no pulses after reset", 32'(n_pulse[0] + n_pulse[1] + n_pulse[2] + n_pulse[3] + n_pulse[4]), 32'd0);

        // table walk: R2..R7, R10
        for (int v = 0; v < NV; v++) begin
            logic [23:0] w;
            int          n;
            int          base [5];
            logic [3:0]  mask;
            logic        err_exp;
            string       tag;
            w = VEC[v][29:6];
            n = int'(VEC[v][5:0]);
            for (int i = 0; i < 5; i++) base[i] = n_pulse[i];
            mask = 4'b0000;
            err_exp = (n != 24);
            if (err_exp) tag = "R7";
            else begin
                case (w[1:0])
                    2'b00: begin tag = "R3"; mask = 4'b0001; end
                    2'b01: begin tag = "R4"; mask = 4'b0010; end
                    2'b10: begin tag = "R5"; mask = 4'b0100; end
                    default: begin tag = "R6"; mask = 4'b1100; end
                endcase
            end
            for (int i = 0; i < 4; i++) if (mask[i]) m_lat[i] = w[23:2];

            send_bits(w, n);
            pulse_le();

            chk({tag, " ref pulse"}, 32'(n_pulse[0] - base[0]), 32'(mask[0]));
            chk({tag, " ab pulse"},  32'(n_pulse[1] - base[1]), 32'(mask[1]));
            chk({tag, " fn pulse"},  32'(n_pulse[2] - base[2]), 32'(mask[2]));
            chk({tag, " ini pulse"}, 32'(n_pulse[3] - base[3]), 32'(mask[3]));
            chk({tag, " error pulse"}, 32'(n_pulse[4] - base[4]), 32'(err_exp));
            check_latches({tag, " R2/R10 register contents"});
        end

        // R8: full word without load strobe, then strobe
        begin
            int base_ab;
            int base_all;
            base_ab  = n_pulse[1];
            base_all = n_pulse[0] + n_pulse[1] + n_pulse[2] + n_pulse[3] + n_pulse[4];
            send_bits(24'h3C3C3D, 24);
            repeat (10) @(negedge clk);
            check_latches("R8 before strobe");
            chk("R8 no pulse before strobe",
                32'(n_pulse[0] + n_pulse[1] + n_pulse[2] + n_pulse[3] + n_pulse[4] - base_all), 32'd0);
            pulse_le();
            m_lat[1] = 22'(24'h3C3C3D >> 2);
            chk("R8 ab pulse after strobe", 32'(n_pulse[1] - base_ab), 32'd1);
            check_latches("R8 after strobe");
        end

        // R9: no pulse lasted two cycles
        chk("R9 pulse width", 32'(n_double), 32'd0);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) m_lat[i] = '0;
        check_latches("R1 reset after traffic");

        summary();
        $finish;
    end

endmodule